// File: doc/BRIEF.md
# Bus-Idle Suspend and Wakeup Controller

This block sits between a full-speed serial bus receiver and an embedded processor and handles low-power entry and exit. In the main clock domain it counts consecutive cycles with no bus activity. After a parameterised idle time (36000 cycles by default, which is 3 ms at 12 MHz) it raises a one-cycle suspend interrupt request. It then stays quiet until bus activity has been seen again.

Software reacts to the suspend request by writing the sleep bit of the control register. An always-on domain, clocked by a slow free-running clock, sees that request and drops the oscillator enable, which stops the main clock. Two wake sources can end low power: the active-low wake pin going low, or bus traffic returning. Either one raises the oscillator enable again from the always-on domain, with no need for the stopped clock.

A resume event is carried back into the main domain by a synchronised toggle. There it does two things:
- It sets a latched resume flag. The flag has its own interrupt enable, and software clears it by writing 0 to it.
- It clears the sleep bit, which returns the block to the running state.

Top module: `susp_wake_ctrl`

## Requirements
- R1: After a cycle in which `bus_act` is sampled high, `susp_irq` is high exactly IDLE_CYCLES clock edges later if `bus_act` stays low in between. It is low one edge earlier.
- R2: `susp_irq` is a one-cycle pulse. Any sampled `bus_act` restarts the idle count. After a pulse, no further pulse occurs until `bus_act` has been seen again.
- R3: The control register layout is: bit 0 is the sleep request, bit 1 is the resume flag, bit 2 is the resume interrupt enable. All other read bits are 0. After reset the register reads 0.
- R4: Writing 1 to bit 0 drops `osc_en` within SYNC_STAGES+2 `aon_clk` cycles. `osc_en` then stays low as long as no wake source is active.
- R5: While `osc_en` is low, holding `wake_n` low for at least SYNC_STAGES+1 `aon_clk` cycles raises `osc_en` within SYNC_STAGES+2 `aon_clk` cycles.
- R6: While `osc_en` is low, holding `bus_act` high for at least SYNC_STAGES+1 `aon_clk` cycles raises `osc_en` in the same way.
- R7: Once the main clock runs again after a wake, the resume flag (bit 1) reads 1 and the sleep bit (bit 0) reads 0. If a resume event and a flag-clearing write land in the same cycle, the flag is set.
- R8: A register write with bit 1 at 0 clears the resume flag. A write with bit 1 at 1 leaves the flag unchanged.
- R9: `irq_resume` is high exactly when the resume flag and the enable bit (bit 2) are both 1.
- R10: A wake source that becomes active while the oscillator is running does not set the resume flag.
- R11: After reset, `osc_en` is 1 and both `susp_irq` and `irq_resume` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Main clock; stops while `osc_en` is low |
| rst | input | 1 | Synchronous active-high reset, main domain |
| aon_clk | input | 1 | Always-on slow clock |
| aon_rst | input | 1 | Synchronous active-high reset, always-on domain |
| bus_act | input | 1 | Bus activity strobe from the receiver |
| wake_n | input | 1 | External wake pin, active low |
| cpu_wr | input | 1 | Control register write strobe |
| cpu_wdata | input | 8 | Control register write data |
| cpu_rdata | output | 8 | Control register read data |
| osc_en | output | 1 | Main oscillator enable |
| susp_irq | output | 1 | Suspend interrupt request pulse |
| irq_resume | output | 1 | Resume interrupt request (flag AND enable) |

## Verification
The hardest state to reach is a wake event that arrives while the main clock is stopped. While the clock is stopped, no main-domain process can make progress.

The bench models the oscillator by gating its own 50 MHz clock with `osc_en`. During sleep it drives and samples only on `aon_clk` edges. It applies each wake source for a few always-on cycles, and only after `osc_en` has returned does it go back to main-clock timing to read the flag and the sleep bit.

The set-versus-clear race on the flag cannot be timed from the ports. A bound property covers it instead.

// File: rtl/susp_wake_pkg.sv
package susp_wake_pkg;

    localparam int REG_W     = 8;
    localparam int BIT_SLEEP = 0;
    localparam int BIT_FLAG  = 1;
    localparam int BIT_EN    = 2;

    typedef struct packed {
        logic irq_en;
        logic res_flag;
        logic sleep_req;
    } ctrl_t;

    function automatic logic [REG_W-1:0] ctrl_to_bus(ctrl_t c);
        logic [REG_W-1:0] v;
        v            = '0;
        v[BIT_SLEEP] = c.sleep_req;
        v[BIT_FLAG]  = c.res_flag;
        v[BIT_EN]    = c.irq_en;
        return v;
    endfunction

endpackage

// File: rtl/sw_sync.sv
module sw_sync #(
    parameter int   STAGES  = 2,
    parameter logic RST_VAL = 1'b0
) (
    input  logic clk,
    input  logic rst,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain;

    generate
        if (STAGES == 1) begin : g_single
            always_ff @(posedge clk) begin
                if (rst) chain <= RST_VAL;
                else     chain <= d;
            end
        end else begin : g_multi
            always_ff @(posedge clk) begin
                if (rst) chain <= {STAGES{RST_VAL}};
                else     chain <= {chain[STAGES-2:0], d};
            end
        end
    endgenerate

    assign q = chain[STAGES-1];
endmodule

// File: rtl/sw_idle_timer.sv
module sw_idle_timer #(
    parameter int IDLE_CYCLES = 36000
) (
    input  logic clk,
    input  logic rst,
    input  logic bus_act,
    output logic susp_irq
);
    localparam int CNT_W = $clog2(IDLE_CYCLES + 1);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(IDLE_CYCLES - 1);

    logic [CNT_W-1:0] cnt;
    logic             armed;
    logic             fire;

    // Pulse on the edge that completes the idle window, once per arming.
    assign fire = armed && !bus_act && (cnt == LAST);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt      <= '0;
            armed    <= 1'b1;
            susp_irq <= 1'b0;
        end else begin
            susp_irq <= fire;
            if (bus_act) begin
                cnt   <= '0;
                armed <= 1'b1;
            end else begin
                if (cnt < LAST) cnt <= cnt + 1'b1;
                if (fire)       armed <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/sw_aon_gate.sv
module sw_aon_gate #(
    parameter int SYNC_STAGES = 2
) (
    input  logic aon_clk,
    input  logic aon_rst,
    input  logic sleep_req,
    input  logic wake_n,
    input  logic bus_act,
    output logic osc_en,
    output logic res_tog,
    output logic gated,
    output logic wake_evt
);
    logic sleep_s, sleep_prev, pin_n_s, act_s, gate_q;

    sw_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_sleep_sync (
        .clk(aon_clk), .rst(aon_rst), .d(sleep_req), .q(sleep_s)
    );
    sw_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_pin_sync (
        .clk(aon_clk), .rst(aon_rst), .d(wake_n), .q(pin_n_s)
    );
    sw_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_act_sync (
        .clk(aon_clk), .rst(aon_rst), .d(bus_act), .q(act_s)
    );

    assign wake_evt = !pin_n_s || act_s;

    always_ff @(posedge aon_clk) begin
        if (aon_rst) begin
            sleep_prev <= 1'b0;
            gate_q     <= 1'b0;
            res_tog    <= 1'b0;
        end else begin
            sleep_prev <= sleep_s;
            if (gate_q && wake_evt) begin
                gate_q  <= 1'b0;
                res_tog <= ~res_tog;
            end else if (sleep_s && !sleep_prev) begin
                gate_q <= 1'b1;
            end
        end
    end

    assign osc_en = !gate_q;
    assign gated  = gate_q;
endmodule

// File: rtl/sw_cpu_regs.sv
module sw_cpu_regs
    import susp_wake_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cpu_wr,
    input  logic [REG_W-1:0] cpu_wdata,
    input  logic             res_tog,
    output logic [REG_W-1:0] cpu_rdata,
    output logic             sleep_req,
    output logic             res_flag,
    output logic             res_pulse,
    output logic             irq_resume
);
    logic  tog_s, tog_prev;
    ctrl_t ctrl;

    sw_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_tog_sync (
        .clk(clk), .rst(rst), .d(res_tog), .q(tog_s)
    );

    assign res_pulse = tog_s ^ tog_prev;

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl     <= '0;
            tog_prev <= 1'b0;
        end else begin
            tog_prev <= tog_s;
            if (cpu_wr) begin
                ctrl.irq_en    <= cpu_wdata[BIT_EN];
                ctrl.sleep_req <= cpu_wdata[BIT_SLEEP];
                if (!cpu_wdata[BIT_FLAG]) ctrl.res_flag <= 1'b0;
            end
            // Resume event overrides any write in the same cycle.
            if (res_pulse) begin
                ctrl.res_flag  <= 1'b1;
                ctrl.sleep_req <= 1'b0;
            end
        end
    end

    assign cpu_rdata  = ctrl_to_bus(ctrl);
    assign sleep_req  = ctrl.sleep_req;
    assign res_flag   = ctrl.res_flag;
    assign irq_resume = ctrl.res_flag && ctrl.irq_en;
endmodule

// File: rtl/susp_wake_ctrl.sv
module susp_wake_ctrl
    import susp_wake_pkg::*;
#(
    parameter int IDLE_CYCLES = 36000,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             aon_clk,
    input  logic             aon_rst,
    input  logic             bus_act,
    input  logic             wake_n,
    input  logic             cpu_wr,
    input  logic [REG_W-1:0] cpu_wdata,
    output logic [REG_W-1:0] cpu_rdata,
    output logic             osc_en,
    output logic             susp_irq,
    output logic             irq_resume
);
    logic sleep_req, res_flag, res_pulse, res_tog, gated, wake_evt;

    sw_idle_timer #(.IDLE_CYCLES(IDLE_CYCLES)) u_timer (
        .clk(clk), .rst(rst), .bus_act(bus_act), .susp_irq(susp_irq)
    );

    sw_aon_gate #(.SYNC_STAGES(SYNC_STAGES)) u_aon (
        .aon_clk(aon_clk), .aon_rst(aon_rst), .sleep_req(sleep_req),
        .wake_n(wake_n), .bus_act(bus_act), .osc_en(osc_en),
        .res_tog(res_tog), .gated(gated), .wake_evt(wake_evt)
    );

    sw_cpu_regs #(.SYNC_STAGES(SYNC_STAGES)) u_regs (
        .clk(clk), .rst(rst), .cpu_wr(cpu_wr), .cpu_wdata(cpu_wdata),
        .res_tog(res_tog), .cpu_rdata(cpu_rdata), .sleep_req(sleep_req),
        .res_flag(res_flag), .res_pulse(res_pulse), .irq_resume(irq_resume)
    );
endmodule

// File: rtl/sw_chk.sv
module sw_chk
    import susp_wake_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic             aon_clk,
    input logic             aon_rst,
    input logic             bus_act,
    input logic             cpu_wr,
    input logic [REG_W-1:0] cpu_wdata,
    input logic [REG_W-1:0] cpu_rdata,
    input logic             susp_irq,
    input logic             irq_resume,
    input logic             osc_en,
    input logic             res_pulse,
    input logic             res_flag,
    input logic             sleep_req,
    input logic             gated,
    input logic             wake_evt
);
    logic rearm_q;

    always_ff @(posedge clk) begin
        if (rst)           rearm_q <= 1'b1;
        else if (bus_act)  rearm_q <= 1'b1;
        else if (susp_irq) rearm_q <= 1'b0;
    end

    // R2
    susp_single_cycle_chk: assert property (@(posedge clk) disable iff (rst)
        susp_irq |=> !susp_irq);

    // R2
    susp_once_per_idle_chk: assert property (@(posedge clk) disable iff (rst)
        susp_irq |-> rearm_q);

    // R2
    act_blocks_susp_chk: assert property (@(posedge clk) disable iff (rst)
        bus_act |=> !susp_irq);

    // R7
    resume_wins_chk: assert property (@(posedge clk) disable iff (rst)
        res_pulse |=> (res_flag && !sleep_req));

    // R8
    flag_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (cpu_wr && !cpu_wdata[BIT_FLAG] && !res_pulse) |=> !res_flag);

    // R9
    irq_needs_enable_chk: assert property (@(posedge clk) disable iff (rst)
        irq_resume |-> (cpu_rdata[BIT_EN] && cpu_rdata[BIT_FLAG]));

    // R4
    gate_holds_chk: assert property (@(posedge aon_clk) disable iff (aon_rst)
        (gated && !wake_evt) |=> !osc_en);

    // R5
    wake_restarts_chk: assert property (@(posedge aon_clk) disable iff (aon_rst)
        (gated && wake_evt) |=> osc_en);
endmodule

bind susp_wake_ctrl sw_chk u_chk (
    .clk(clk), .rst(rst), .aon_clk(aon_clk), .aon_rst(aon_rst),
    .bus_act(bus_act), .cpu_wr(cpu_wr), .cpu_wdata(cpu_wdata),
    .cpu_rdata(cpu_rdata), .susp_irq(susp_irq), .irq_resume(irq_resume),
    .osc_en(osc_en), .res_pulse(res_pulse), .res_flag(res_flag),
    .sleep_req(sleep_req), .gated(gated), .wake_evt(wake_evt)
);

// File: tb/susp_wake_ctrl_bench.sv
module susp_wake_ctrl_bench;
    localparam int IDLE = 40;

    logic       clk = 1'b0;
    logic       aon_clk = 1'b0;
    logic       rst, aon_rst, bus_act, wake_n, cpu_wr;
    logic [7:0] cpu_wdata, cpu_rdata;
    logic       osc_en, susp_irq, irq_resume;

    int checks   = 0;
    int failures = 0;

    // Main clock models the oscillator: 50 MHz while enabled, held low when stopped.
    always #10 clk = (osc_en === 1'b0) ? 1'b0 : ~clk;
    always #80 aon_clk = ~aon_clk;

    susp_wake_ctrl #(.IDLE_CYCLES(IDLE), .SYNC_STAGES(2)) u_susp_wake_ctrl (
        .clk(clk), .rst(rst), .aon_clk(aon_clk), .aon_rst(aon_rst),
        .bus_act(bus_act), .wake_n(wake_n), .cpu_wr(cpu_wr),
        .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata), .osc_en(osc_en),
        .susp_irq(susp_irq), .irq_resume(irq_resume)
    );

    // {write data, expected read data}; flag is 0 throughout.
    localparam logic [15:0] VEC [5] = '{16'h0404, 16'h0000, 16'h0604,
                                        16'hFA00, 16'h0200};

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic clk_neg(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic aon_neg(input int n);
        repeat (n) @(negedge aon_clk);
    endtask

    task automatic cpu_write(input logic [7:0] d);
        @(negedge clk);
        cpu_wr    = 1'b1;
        cpu_wdata = d;
        @(negedge clk);
        cpu_wr    = 1'b0;
    endtask

    task automatic strobe();
        @(negedge clk);
        bus_act = 1'b1;
        @(negedge clk);
        bus_act = 1'b0;
    endtask

    initial begin
        #4000000;
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        int pulses;
        rst = 1'b1; aon_rst = 1'b1; bus_act = 1'b0; wake_n = 1'b1;
        cpu_wr = 1'b0; cpu_wdata = '0;
        aon_neg(3);
        aon_rst = 1'b0;
        @(negedge clk);
        rst = 1'b0;
        clk_neg(1);

        // R11 / R3 reset state
        check("R11 osc_en", osc_en, 1);
        check("R11 irq_resume", irq_resume, 0);
        check("R3 reset rdata", cpu_rdata, 8'h00);

        // R1 threshold timing
        strobe();
        clk_neg(IDLE - 1);
        check("R1 one short", susp_irq, 0);
        clk_neg(1);
        check("R1 at threshold", susp_irq, 1);
        clk_neg(1);
        check("R2 single cycle", susp_irq, 0);
        pulses = 0;
        for (int i = 0; i < 3 * IDLE; i++) begin
            @(negedge clk);
            if (susp_irq) pulses++;
        end
        check("R2 no re-fire", pulses, 0);

        // R2 activity restarts count
        strobe();
        clk_neg(IDLE - 5);
        strobe();
        clk_neg(IDLE - 1);
        check("R2 restart short", susp_irq, 0);
        clk_neg(1);
        check("R2 restart fires", susp_irq, 1);

        // R3 / R8 register vectors
        for (int i = 0; i < 5; i++) begin
            cpu_write(VEC[i][15:8]);
            check("R3 R8 vector rdata", cpu_rdata, VEC[i][7:0]);
            check("R9 vector irq", irq_resume, 0);
        end

        // R4 / R5 sleep and wake by pin
        cpu_write(8'h01);
        aon_neg(8);
        check("R4 osc gated", osc_en, 0);
        aon_neg(20);
        check("R4 stays gated", osc_en, 0);
        wake_n = 1'b0;
        aon_neg(4);
        wake_n = 1'b1;
        aon_neg(4);
        check("R5 pin wake", osc_en, 1);
        clk_neg(10);
        check("R7 flag set sleep clear", cpu_rdata, 8'h02);
        check("R9 masked", irq_resume, 0);
        cpu_write(8'h06);
        check("R8 write1 keeps flag", cpu_rdata, 8'h06);
        check("R9 unmasked", irq_resume, 1);
        cpu_write(8'h04);
        check("R8 clear", cpu_rdata, 8'h04);
        check("R9 cleared", irq_resume, 0);

        // R6 sleep and wake by bus activity
        cpu_write(8'h05);
        aon_neg(8);
        check("R4 osc gated again", osc_en, 0);
        bus_act = 1'b1;
        aon_neg(4);
        bus_act = 1'b0;
        aon_neg(4);
        check("R6 bus wake", osc_en, 1);
        clk_neg(10);
        check("R7 flag after bus wake", cpu_rdata, 8'h06);
        check("R9 irq after bus wake", irq_resume, 1);

        // R10 wake while running
        cpu_write(8'h04);
        wake_n = 1'b0;
        aon_neg(4);
        wake_n = 1'b1;
        aon_neg(4);
        clk_neg(4);
        check("R10 no flag when running", cpu_rdata, 8'h04);
        check("R10 osc still on", osc_en, 1);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule